// File: doc/BRIEF.md
# Signed Integer Format Converter

This block re-encodes a signed integer from one of three fixed-width encodings into another: two's complement, sign-magnitude, or offset binary. A 2-bit select on each side picks the source and destination encodings. When the extend input is high, the result is written in a wider field. The same value is then encoded at the wide width: two's complement is sign-extended, sign-magnitude puts its sign in the new top bit, and offset binary uses the wide bias.

The conversion itself is combinational. It decodes the input into a canonical two's complement value, then encodes that value into the target format. An optional register stage sits on the outputs.

Two flags go with each result:
- The negative-zero flag marks a sign-magnitude input that holds its negative zero code.
- The unrepresentable flag marks the one value that sign-magnitude cannot hold in the narrow field. This is the most negative two's complement value, and the output saturates in that case.

Top module: `sint_fmt_conv`

## Requirements
- R1: The format code on `src_fmt_i` and `dst_fmt_i` is 2'b00 for two's complement, 2'b01 for sign-magnitude and 2'b10 for offset binary. Code 2'b11 behaves exactly like 2'b00 on both selects.
- R2: A sign-magnitude word has its sign in the MSB (1 = negative) and the unsigned magnitude in the bits below. Conversion between sign-magnitude and two's complement preserves the numeric value.
- R3: Both sign-magnitude zeros, 0000_0000 and 1000_0000, convert to the zero code of the destination format. For offset binary that zero code is 1000_0000.
- R4: `neg_zero_o` is 1 exactly when the source format is sign-magnitude and `data_i` is 1000_0000. It is 0 for every other input.
- R5: Offset binary codes a value v as 2^(W-1)+v, so 8-bit +22 is 1001_0110 and -7 is 0111_1001. Conversion to and from two's complement is an inversion of the MSB.
- R6: The value -2^(W-1) (1000_0000 in two's complement, or 0000_0000 in offset binary) sent to narrow sign-magnitude gives 1111_1111 with `unrep_o` = 1. For every other case `unrep_o` = 0.
- R7: With `ext_i` = 0 the result occupies `data_o[W-1:0]` and the upper XW-W bits are 0. With `ext_i` = 1 the full XW-bit field carries the same value in the destination format:
  - two's complement is sign-extended;
  - sign-magnitude puts the sign at bit XW-1 with the magnitude below;
  - offset binary uses the bias 2^(XW-1).
  No value is unrepresentable in the wide field.
- R8: With REG_OUT = 1, all outputs are registered. A change on the inputs appears one clock after it is applied. While `rst_ni` is low, every output is 0.
- R9: Converting any code from format A to format B, and then converting the result back from B to A, returns the original code. This holds wherever B can represent the value. The exception is sign-magnitude negative zero, which comes back as 0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | W | Input code |
| src_fmt_i | input | 2 | Source format select |
| dst_fmt_i | input | 2 | Destination format select |
| ext_i | input | 1 | Selects the XW-bit output field |
| data_o | output | XW | Converted code |
| neg_zero_o | output | 1 | Input was sign-magnitude negative zero |
| unrep_o | output | 1 | Value has no narrow sign-magnitude code; output saturated |

## Verification
The bench tests every input code under every pairing of source and destination format, in both field widths, and compares each result with an arithmetic model. It aims at the following corner cases:
- **Negative zero.** A design that passed this code straight through would emit -0 into two's complement as -128, or into offset binary as 0000_0000.
- **Most negative value into sign-magnitude.** Naive negation wraps here and would produce 1000_0000, which reads as negative zero, with no flag raised.
- **Wide field.** A zero-filling design would break negative two's complement values. Plain sign extension would corrupt sign-magnitude and offset binary, because those need a relocated sign bit and a new bias.
- **Round trips.** Converting every code into each other format and back catches any asymmetry between the decoder and the encoder.

// File: rtl/sint_fmt_pkg.sv
package sint_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_TC     = 2'b00,
    FMT_SM     = 2'b01,
    FMT_OB     = 2'b10,
    FMT_TC_ALT = 2'b11
  } fmt_e;
endpackage

// File: rtl/sint_fmt_dec.sv
module sint_fmt_dec
  import sint_fmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  fmt_e         fmt_i,
  output logic [W-1:0] val_o,
  output logic         neg_zero_o
);
  localparam logic [W-1:0] ONE   = W'(1);
  localparam logic [W-1:0] MIN_C = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mag;

  always_comb begin
    mag = {1'b0, data_i[W-2:0]};
    unique case (fmt_i)
      FMT_SM:  val_o = data_i[W-1] ? (~mag) + ONE : mag;
      FMT_OB:  val_o = {~data_i[W-1], data_i[W-2:0]};
      default: val_o = data_i;
    endcase
  end

  assign neg_zero_o = (fmt_i == FMT_SM) && (data_i == MIN_C);
endmodule

// File: rtl/sint_fmt_enc.sv
module sint_fmt_enc
  import sint_fmt_pkg::*;
#(
  parameter int IW = 8,
  parameter int OW = 8
) (
  input  logic [IW-1:0] val_i,
  input  fmt_e          fmt_i,
  output logic [OW-1:0] code_o,
  output logic          unrep_o
);
  localparam int XB = OW - IW;
  localparam logic [OW-1:0] ONE = OW'(1);

  logic [OW-1:0] vx;
  logic [OW-1:0] neg;

  if (XB > 0) begin : g_sext
    assign vx = {{XB{val_i[IW-1]}}, val_i};
  end else begin : g_same
    assign vx = val_i;
  end

  assign neg = (~vx) + ONE;

  always_comb begin
    unrep_o = 1'b0;
    unique case (fmt_i)
      FMT_SM: begin
        if (!vx[OW-1]) begin
          code_o = vx;
        end else if (neg[OW-1]) begin
          // most negative value: no magnitude code fits, saturate
          code_o  = '1;
          unrep_o = 1'b1;
        end else begin
          code_o = {1'b1, neg[OW-2:0]};
        end
      end
      FMT_OB:  code_o = {~vx[OW-1], vx[OW-2:0]};
      default: code_o = vx;
    endcase
  end
endmodule

// File: rtl/sint_fmt_oreg.sv
module sint_fmt_oreg #(
  parameter int N       = 18,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/sint_fmt_conv.sv
module sint_fmt_conv
  import sint_fmt_pkg::*;
#(
  parameter int W       = 8,
  parameter int XW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  data_i,
  input  logic [1:0]    src_fmt_i,
  input  logic [1:0]    dst_fmt_i,
  input  logic          ext_i,
  output logic [XW-1:0] data_o,
  output logic          neg_zero_o,
  output logic          unrep_o
);
  localparam int PAD = XW - W;
  localparam int NO  = XW + 2;

  fmt_e          src_fmt, dst_fmt;
  logic [W-1:0]  val;
  logic          nz;
  logic [W-1:0]  code_n;
  logic [XW-1:0] code_w;
  logic          unrep_n, unrep_w;
  logic [XW-1:0] code_sel;
  logic          unrep_sel;
  logic [NO-1:0] out_d, out_q;

  assign src_fmt = fmt_e'(src_fmt_i);
  assign dst_fmt = fmt_e'(dst_fmt_i);

  sint_fmt_dec #(.W(W)) u_dec (
    .data_i     (data_i),
    .fmt_i      (src_fmt),
    .val_o      (val),
    .neg_zero_o (nz)
  );

  sint_fmt_enc #(.IW(W), .OW(W)) u_enc_n (
    .val_i   (val),
    .fmt_i   (dst_fmt),
    .code_o  (code_n),
    .unrep_o (unrep_n)
  );

  sint_fmt_enc #(.IW(W), .OW(XW)) u_enc_w (
    .val_i   (val),
    .fmt_i   (dst_fmt),
    .code_o  (code_w),
    .unrep_o (unrep_w)
  );

  always_comb begin
    if (ext_i) begin
      code_sel  = code_w;
      unrep_sel = unrep_w;
    end else begin
      code_sel  = {{PAD{1'b0}}, code_n};
      unrep_sel = unrep_n;
    end
  end

  assign out_d = {nz, unrep_sel, code_sel};

  sint_fmt_oreg #(.N(NO), .REG_OUT(REG_OUT)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (out_d),
    .q_o    (out_q)
  );

  assign data_o     = out_q[XW-1:0];
  assign unrep_o    = out_q[XW];
  assign neg_zero_o = out_q[XW+1];
endmodule

// File: rtl/sint_fmt_conv_chk.sv
module sint_fmt_conv_chk #(
  parameter int W       = 8,
  parameter int XW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  data_i,
  input logic [1:0]    src_fmt_i,
  input logic [1:0]    dst_fmt_i,
  input logic          ext_i,
  input logic [XW-1:0] data_o,
  input logic          neg_zero_o,
  input logic          unrep_o
);
  localparam logic [W-1:0]  MIN_C = {1'b1, {(W-1){1'b0}}};
  localparam logic [XW-1:0] SAT_C = {{(XW-W){1'b0}}, {W{1'b1}}};

  // R4 R6
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({neg_zero_o, unrep_o}));

  // R6
  unrep_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unrep_o |-> (data_o == SAT_C));

  if (REG_OUT) begin : g_seq
    // R4
    neg_zero_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_fmt_i == 2'b01 && data_i == MIN_C) |=> neg_zero_o);

    // R4
    neg_zero_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_fmt_i != 2'b01) |=> !neg_zero_o);

    // R5
    ob_to_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_i && src_fmt_i == 2'b10 && dst_fmt_i == 2'b00) |=>
      (data_o[W-1] == !$past(data_i[W-1]) && data_o[W-2:0] == $past(data_i[W-2:0])));

    if (XW > W) begin : g_wide
      // R7
      ext_no_unrep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_i |=> !unrep_o);

      // R7
      narrow_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ext_i |=> (data_o[XW-1:W] == '0));

      // R7
      tc_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_i && dst_fmt_i == 2'b00) |=> (data_o[XW-1:W] == {(XW-W){data_o[W-1]}}));
    end
  end
endmodule

bind sint_fmt_conv sint_fmt_conv_chk #(.W(W), .XW(XW), .REG_OUT(REG_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .src_fmt_i  (src_fmt_i),
  .dst_fmt_i  (dst_fmt_i),
  .ext_i      (ext_i),
  .data_o     (data_o),
  .neg_zero_o (neg_zero_o),
  .unrep_o    (unrep_o)
);

// File: tb/sim_sint_fmt_conv.sv
`timescale 1ns/1ps
module sim_sint_fmt_conv;
  localparam int W  = 8;
  localparam int XW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  din = '0;
  logic [1:0]    sfmt = '0, dfmt = '0;
  logic          ext = 1'b0;
  logic [XW-1:0] dout;
  logic          nz, ur;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sint_fmt_conv #(.W(W), .XW(XW), .REG_OUT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .src_fmt_i(sfmt),
    .dst_fmt_i(dfmt), .ext_i(ext), .data_o(dout), .neg_zero_o(nz), .unrep_o(ur)
  );

  function automatic int dec_val(int d, int f);
    if (f == 1) return ((d >> (W-1)) & 1) ? -(d % (1 << (W-1))) : (d % (1 << (W-1)));
    if (f == 2) return d - (1 << (W-1));
    return (d >= (1 << (W-1))) ? d - (1 << W) : d;
  endfunction

  function automatic int enc_code(int v, int f, int ow, output bit unrep);
    int half;
    half  = 1 << (ow-1);
    unrep = 1'b0;
    if (f == 1) begin
      if (v >= 0) return v;
      if (-v >= half) begin
        unrep = 1'b1;
        return (1 << W) - 1;
      end
      return half + (-v);
    end
    if (f == 2) return v + half;
    return (v < 0) ? v + (1 << ow) : v;
  endfunction

  function automatic string tag_of(int s, int d, int e, int x, bit u, bit z);
    if (u) return "R6";
    if (z) return "R4";
    if (s == 3 || d == 3) return "R1";
    if (e != 0) return "R7";
    if (s == 2 || d == 2) return "R5";
    if (s == 1 && (x % (1 << (W-1))) == 0) return "R3";
    return "R2";
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(int x, int s, int d, int e);
    din  = W'(x);
    sfmt = 2'(s);
    dfmt = 2'(d);
    ext  = e[0];
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int ev, ex, y, y_ur;
    bit eu;
    // R8: reset clears outputs
    din = 8'hA5; sfmt = 2'b01; dfmt = 2'b10; ext = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout == '0, "R8", "reset data_o", int'(dout), 0);
    chk(nz == 1'b0 && ur == 1'b0, "R8", "reset flags", int'({nz, ur}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int e = 0; e < 2; e++)
          for (int x = 0; x < (1 << W); x++) begin
            bit ez;
            drive(x, s, d, e);
            ev = dec_val(x, (s == 3) ? 0 : s);
            ex = enc_code(ev, (d == 3) ? 0 : d, (e != 0) ? XW : W, eu);
            ez = (s == 1) && (x == (1 << (W-1)));
            chk(int'(dout) == ex, tag_of(s, d, e, x, eu, ez), "data_o", int'(dout), ex);
            chk(nz == ez, "R4", "neg_zero_o", int'(nz), int'(ez));
            chk(ur == eu, "R6", "unrep_o", int'(ur), int'(eu));
          end

    // R9: round trips
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 3; d++)
        if (s != d)
          for (int x = 0; x < (1 << W); x++) begin
            drive(x, s, d, 0);
            y    = int'(dout[W-1:0]);
            y_ur = int'(ur);
            drive(y, d, s, 0);
            if (y_ur == 0) begin
              ex = (s == 1 && x == (1 << (W-1))) ? 0 : x;
              chk(int'(dout) == ex, "R9", "round trip", int'(dout), ex);
            end
          end

    // R8: one-cycle latency
    drive(8'h05, 0, 0, 0);
    din = 8'h05; sfmt = 2'b00; dfmt = 2'b10; ext = 1'b0;
    #1;
    chk(int'(dout) == 16'h0005, "R8", "before edge", int'(dout), 16'h0005);
    @(posedge clk);
    #1;
    chk(int'(dout) == 16'h0085, "R8", "after edge", int'(dout), 16'h0085);

    summary();
  end
endmodule